// File: doc/BRIEF.md
# Receive Queue with Optional Timestamp Pairing

This block buffers the words that one synchronous serial receiver produces for a host. Every incoming word carries a flag that says whether it arrived free of timing faults. Only clean words are stored. A mode input, `stamp_mode`, decides how each word is stored. When the mode is off, each word takes one entry, so the full depth holds data. When the mode is on, the word and the timestamp that came with it are written in the same cycle into two adjacent entries, data first. This halves the number of words the queue can hold.

The host drains the queue through a read strobe. The data appears one cycle after the strobe. The queue reports when it is empty, when it is half full, when it is full, and a single-cycle event when it becomes full. It also keeps an overrun flag that stays set until the host clears it, and a staleness flag for data that has waited too long. A single transfer request combines the half-full level, the overrun flag and the staleness flag, and tells the host that a drain is due.

Top module: `rxq_stamp_fifo`

## Requirements
- R1: After reset the queue is empty, and half-full, full, full event, overrun, stale and transfer request are all low.
- R2: With `stamp_mode` low, each clean word takes one entry, and words read back in arrival order. Read data is valid, with `rd_valid` high, in the cycle after an accepted `rd_en`.
- R3: With `stamp_mode` high, a clean word and its timestamp are stored as two adjacent entries. The first read returns the word and the second returns its timestamp.
- R4: A word presented with `in_clean` low is not stored and does not set overrun.
- R5: With `stamp_mode` low, the queue holds exactly DEPTH words and raises `full` at that point. A further clean word is discarded and does not disturb the stored contents.
- R6: With `stamp_mode` high, a word is stored only if at least two entries are free. Otherwise both the word and its timestamp are discarded and overrun is set, so a pair is never split.
- R7: Overrun is set when a clean word is discarded for lack of space. It stays set until `ovr_clr` is pulsed. If a discard and a clear happen in the same cycle, the flag stays set.
- R8: `half_full` is high while the occupancy is at least DEPTH/2 entries.
- R9: `full_evt` is high for exactly one cycle, in the cycle after the write that fills the queue.
- R10: `stale` goes high once `tmo_limit` clock edges have passed since the last stored write, while the queue is non-empty and below half full. Each stored write restarts the count. A limit of zero disables the flag.
- R11: `xfer_req` is the OR of `half_full`, overrun and `stale`.
- R12: A read strobe while the queue is empty is ignored and produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stamp_mode | input | 1 | 1: store a timestamp after each word |
| tmo_limit | input | TMO_W | Idle edges before `stale`; 0 disables |
| in_valid | input | 1 | Receiver offers a word this cycle |
| in_clean | input | 1 | Offered word had no timing fault |
| in_word | input | DATA_W | Received data word |
| in_stamp | input | DATA_W | Timestamp of the word |
| rd_en | input | 1 | Host read strobe |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | DATA_W | Read entry, valid with `rd_valid` |
| rd_valid | output | 1 | Entry on `rd_data` is from an accepted read |
| empty | output | 1 | No entries stored |
| half_full | output | 1 | Occupancy at or above DEPTH/2 |
| full | output | 1 | Occupancy equals DEPTH |
| full_evt | output | 1 | One-cycle pulse on becoming full |
| overrun | output | 1 | Sticky discard flag |
| stale | output | 1 | Idle timeout expired |
| xfer_req | output | 1 | Host transfer request |

## Verification
The bench targets the pairing boundary. It leaves exactly one free entry in stamp mode and checks that neither half of the pair lands. A design that checks for only one free slot would store the word, push the timestamp over the top, and read back a corrupted sequence. The bench also times the stale flag to the exact edge, checks that a second write restarts it, and checks that it stays quiet when the queue is empty or at the watermark. An off-by-one counter, or a counter that is never restarted, shows up as a flag one cycle early or late. Full-then-overflow readback in single mode catches a design that overwrites the oldest entry. The same-cycle overflow and clear check catches a design that lets the clear win.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_ONE  = 2'd1,
        WR_PAIR = 2'd2,
        WR_DROP = 2'd3
    } wr_act_e;

    function automatic int unsigned slots_needed(input logic stamp_on);
        return stamp_on ? 2 : 1;
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2048,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  rxq_pkg::wr_act_e  act,
    input  logic [AW-1:0]     wptr,
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] stamp,
    input  logic              rd_go,
    input  logic [AW-1:0]     rptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_n;

    assign wptr_n = wptr + AW'(1);

    always_ff @(posedge clk) begin
        if (act == rxq_pkg::WR_ONE || act == rxq_pkg::WR_PAIR)
            mem[wptr] <= word;
        if (act == rxq_pkg::WR_PAIR)
            mem[wptr_n] <= stamp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go)
                rd_data <= mem[rptr];
        end
    end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stamp_mode,
    input  logic             in_valid,
    input  logic             in_clean,
    input  logic             rd_en,
    input  logic             ovr_clr,
    output rxq_pkg::wr_act_e act,
    output logic [AW-1:0]    wptr,
    output logic [AW-1:0]    rptr,
    output logic             rd_go,
    output logic [CW-1:0]    occ,
    output logic             full_evt,
    output logic             overrun
);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic [CW-1:0] free_slots;
    logic [CW-1:0] added;
    logic [CW-1:0] occ_nxt;

    assign free_slots = CAP - occ;
    assign rd_go      = rd_en && (occ != '0);

    always_comb begin
        act   = rxq_pkg::WR_NONE;
        added = '0;
        if (in_valid && in_clean) begin
            if (free_slots < CW'(rxq_pkg::slots_needed(stamp_mode))) begin
                act = rxq_pkg::WR_DROP;
            end else if (stamp_mode) begin
                act   = rxq_pkg::WR_PAIR;
                added = CW'(2);
            end else begin
                act   = rxq_pkg::WR_ONE;
                added = CW'(1);
            end
        end
        occ_nxt = occ + added - (rd_go ? CW'(1) : CW'(0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ      <= '0;
            wptr     <= '0;
            rptr     <= '0;
            full_evt <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            occ      <= occ_nxt;
            wptr     <= wptr + added[AW-1:0];
            if (rd_go)
                rptr <= rptr + AW'(1);
            full_evt <= (occ_nxt == CAP) && (occ != CAP);
            if (act == rxq_pkg::WR_DROP)
                overrun <= 1'b1;
            else if (ovr_clr)
                overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_idle.sv
module rxq_idle #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrote,
    input  logic             armed,
    input  logic [TMO_W-1:0] limit,
    output logic             stale
);
    logic [TMO_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            idle_cnt <= '0;
        else if (wrote)
            idle_cnt <= '0;
        else if (idle_cnt != '1)
            idle_cnt <= idle_cnt + TMO_W'(1);
    end

    assign stale = armed && (limit != '0) && (idle_cnt >= limit);
endmodule

// File: rtl/rxq_stamp_fifo.sv
module rxq_stamp_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2048,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stamp_mode,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              in_valid,
    input  logic              in_clean,
    input  logic [DATA_W-1:0] in_word,
    input  logic [DATA_W-1:0] in_stamp,
    input  logic              rd_en,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              half_full,
    output logic              full,
    output logic              full_evt,
    output logic              overrun,
    output logic              stale,
    output logic              xfer_req
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    rxq_pkg::wr_act_e act;
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic             rd_go;
    logic [CW-1:0]    occ;
    logic             wrote;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .stamp_mode(stamp_mode),
        .in_valid(in_valid), .in_clean(in_clean), .rd_en(rd_en),
        .ovr_clr(ovr_clr), .act(act), .wptr(wptr), .rptr(rptr),
        .rd_go(rd_go), .occ(occ), .full_evt(full_evt), .overrun(overrun)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .act(act), .wptr(wptr),
        .word(in_word), .stamp(in_stamp), .rd_go(rd_go), .rptr(rptr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign wrote     = (act == rxq_pkg::WR_ONE) || (act == rxq_pkg::WR_PAIR);
    assign empty     = (occ == '0);
    assign half_full = (occ >= HALF);
    assign full      = (occ == CW'(DEPTH));

    rxq_idle #(.TMO_W(TMO_W)) u_idle (
        .clk(clk), .rst(rst), .wrote(wrote),
        .armed(!empty && !half_full), .limit(tmo_limit), .stale(stale)
    );

    assign xfer_req = half_full || overrun || stale;
endmodule

// File: rtl/rxq_stamp_fifo_chk.sv
module rxq_stamp_fifo_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_clean,
    input logic rd_en,
    input logic ovr_clr,
    input logic rd_valid,
    input logic empty,
    input logic half_full,
    input logic full,
    input logic full_evt,
    input logic overrun,
    input logic stale
);
    p_dirty_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_clean && !rd_en && empty) |=> empty);

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);

    p_full_evt_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        full_evt |=> !full_evt);

    p_full_evt_full_r9: assert property (@(posedge clk) disable iff (rst)
        full_evt |-> full || $past(rd_en));

    p_full_implies_half_r8: assert property (@(posedge clk) disable iff (rst)
        full |-> half_full);

    p_stale_window_r10: assert property (@(posedge clk) disable iff (rst)
        stale |-> (!empty && !half_full));

    p_empty_read_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> !rd_valid);

    p_empty_not_full_r5: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));
endmodule

bind rxq_stamp_fifo rxq_stamp_fifo_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_clean(in_clean),
    .rd_en(rd_en), .ovr_clr(ovr_clr), .rd_valid(rd_valid), .empty(empty),
    .half_full(half_full), .full(full), .full_evt(full_evt),
    .overrun(overrun), .stale(stale)
);

// File: tb/test_rxq_stamp_fifo.sv
module test_rxq_stamp_fifo;
    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stamp_mode = 1'b0;
    logic [TW-1:0] tmo_limit = '0;
    logic in_valid = 1'b0, in_clean = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
    logic [DW-1:0] in_word = '0, in_stamp = '0;
    logic [DW-1:0] rd_data;
    logic rd_valid, empty, half_full, full, full_evt, overrun, stale, xfer_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rxq_stamp_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .TMO_W(TW)) i_rxq_stamp_fifo (
        .clk(clk), .rst(rst), .stamp_mode(stamp_mode), .tmo_limit(tmo_limit),
        .in_valid(in_valid), .in_clean(in_clean), .in_word(in_word),
        .in_stamp(in_stamp), .rd_en(rd_en), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
        .half_full(half_full), .full(full), .full_evt(full_evt),
        .overrun(overrun), .stale(stale), .xfer_req(xfer_req)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 0; rd_en = 0; ovr_clr = 0; in_clean = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic clean, input logic [DW-1:0] w, input logic [DW-1:0] s);
        in_valid = 1'b1; in_clean = clean; in_word = w; in_stamp = s;
        @(negedge clk);
        in_valid = 1'b0; in_clean = 1'b0;
    endtask

    task automatic pop(input string req, input logic [DW-1:0] exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk({req, " rd_valid"}, DW'(rd_valid), 1);
        chk({req, " rd_data"}, rd_data, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_r1();
        do_reset();
        chk("R1 empty", DW'(empty), 1);
        chk("R1 half/full/evt", DW'({half_full, full, full_evt}), 0);
        chk("R1 overrun/stale/xfer", DW'({overrun, stale, xfer_req}), 0);
    endtask

    task automatic t_order_r2();
        do_reset(); stamp_mode = 0;
        push(1, 32'hA1, 32'h0); push(1, 32'hB2, 32'h0); push(1, 32'hC3, 32'h0);
        chk("R2 not empty", DW'(empty), 0);
        pop("R2 first", 32'hA1); pop("R2 second", 32'hB2); pop("R2 third", 32'hC3);
        chk("R2 drained", DW'(empty), 1);
    endtask

    task automatic t_pair_r3();
        do_reset(); stamp_mode = 1;
        push(1, 32'h1111, 32'h5001); push(1, 32'h2222, 32'h5002);
        pop("R3 word0", 32'h1111); pop("R3 stamp0", 32'h5001);
        pop("R3 word1", 32'h2222); pop("R3 stamp1", 32'h5002);
        chk("R3 drained", DW'(empty), 1);
        stamp_mode = 0;
    endtask

    task automatic t_dirty_r4();
        do_reset(); stamp_mode = 0;
        push(0, 32'hDEAD, 32'h0);
        chk("R4 still empty", DW'(empty), 1);
        chk("R4 no overrun", DW'(overrun), 0);
        push(1, 32'h77, 32'h0); push(0, 32'hBEEF, 32'h0);
        pop("R4 only clean word", 32'h77);
        chk("R4 dirty not stored", DW'(empty), 1);
    endtask

    task automatic t_full_single_r5_r9();
        do_reset(); stamp_mode = 0;
        for (int i = 0; i < DEPTH; i++) begin
            push(1, 32'h100 + DW'(i), 32'h0);
            if (i == DEPTH - 1) chk("R9 full_evt on fill", DW'(full_evt), 1);
            else if (i > 0) chk("R9 no early full_evt", DW'(full_evt), 0);
        end
        chk("R5 full", DW'(full), 1);
        chk("R8 half at full", DW'(half_full), 1);
        push(1, 32'h999, 32'h0);
        chk("R9 pulse ended", DW'(full_evt), 0);
        chk("R5 overflow sets overrun", DW'(overrun), 1);
        for (int i = 0; i < DEPTH; i++) pop("R5 readback", 32'h100 + DW'(i));
        chk("R5 extra word dropped", DW'(empty), 1);
    endtask

    task automatic t_pair_atomic_r6();
        do_reset(); stamp_mode = 0;
        for (int i = 0; i < DEPTH - 1; i++) push(1, DW'(i), 32'h0);
        stamp_mode = 1;
        push(1, 32'hAAAA, 32'hBBBB);
        chk("R6 pair dropped, overrun", DW'(overrun), 1);
        chk("R6 not full", DW'(full), 0);
        stamp_mode = 0;
        for (int i = 0; i < DEPTH - 1; i++) pop("R6 readback", DW'(i));
        chk("R6 no half pair stored", DW'(empty), 1);
        do_reset(); stamp_mode = 1;
        for (int i = 0; i < DEPTH / 2; i++) push(1, DW'(i), 32'hF0 + DW'(i));
        chk("R6 pairs fill queue", DW'(full), 1);
        chk("R6 no overrun at capacity", DW'(overrun), 0);
        stamp_mode = 0;
    endtask

    task automatic t_overrun_r7_r11();
        do_reset(); stamp_mode = 0;
        for (int i = 0; i < DEPTH; i++) push(1, DW'(i), 32'h0);
        push(1, 32'h5, 32'h0);
        for (int i = 0; i < DEPTH; i++) pop("R7 drain", DW'(i));
        idle(3);
        chk("R7 sticky after drain", DW'(overrun), 1);
        chk("R11 xfer from overrun", DW'(xfer_req), 1);
        ovr_clr = 1; @(negedge clk); ovr_clr = 0;
        chk("R7 cleared", DW'(overrun), 0);
        chk("R11 xfer low", DW'(xfer_req), 0);
        for (int i = 0; i < DEPTH; i++) push(1, DW'(i), 32'h0);
        in_valid = 1; in_clean = 1; ovr_clr = 1;
        @(negedge clk);
        in_valid = 0; in_clean = 0; ovr_clr = 0;
        chk("R7 set wins over clear", DW'(overrun), 1);
    endtask

    task automatic t_half_r8();
        do_reset(); stamp_mode = 0;
        for (int i = 0; i < DEPTH / 2 - 1; i++) push(1, DW'(i), 32'h0);
        chk("R8 below watermark", DW'(half_full), 0);
        chk("R11 no xfer below", DW'(xfer_req), 0);
        push(1, 32'h0, 32'h0);
        chk("R8 at watermark", DW'(half_full), 1);
        chk("R11 xfer at watermark", DW'(xfer_req), 1);
        pop("R8 read one", 32'h0);
        chk("R8 back below", DW'(half_full), 0);
    endtask

    task automatic t_stale_r10();
        do_reset(); stamp_mode = 0; tmo_limit = TW'(5);
        idle(10);
        chk("R10 no stale when empty", DW'(stale), 0);
        push(1, 32'h1, 32'h0);
        idle(4);
        chk("R10 not yet", DW'(stale), 0);
        idle(1);
        chk("R10 fires at limit", DW'(stale), 1);
        chk("R11 xfer from stale", DW'(xfer_req), 1);
        push(1, 32'h2, 32'h0);
        chk("R10 write restarts", DW'(stale), 0);
        idle(4);
        chk("R10 restarted count", DW'(stale), 0);
        idle(1);
        chk("R10 fires again", DW'(stale), 1);
        for (int i = 0; i < DEPTH / 2 - 2; i++) push(1, DW'(i), 32'h0);
        idle(12);
        chk("R10 quiet at watermark", DW'(stale), 0);
        tmo_limit = '0;
        do_reset(); push(1, 32'h3, 32'h0); idle(20);
        chk("R10 zero limit disables", DW'(stale), 0);
    endtask

    task automatic t_empty_read_r12();
        do_reset();
        rd_en = 1; @(negedge clk); rd_en = 0;
        chk("R12 no rd_valid on empty", DW'(rd_valid), 0);
        chk("R12 still empty", DW'(empty), 1);
        push(1, 32'h42, 32'h0);
        pop("R12 pointer intact", 32'h42);
    endtask

    initial begin
        t_reset_r1();
        t_order_r2();
        t_pair_r3();
        t_dirty_r4();
        t_full_single_r5_r9();
        t_pair_atomic_r6();
        t_overrun_r7_r11();
        t_half_r8();
        t_stale_r10();
        t_empty_read_r12();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule